// File: doc/BRIEF.md
# Bidirectional Octal Parity Transceiver

This block is a purely combinational bus transceiver for an eight-bit data path that adds a parity bit. A direction input picks the flow: when it is high, data presented on side A is passed to side B; when it is low, data on side B is passed to side A. An active-low enable releases every driven pin when it is high, so the block can share both buses with other agents.

A single parity pin serves both directions. While transmitting, the block drives the parity bit computed from side A. While receiving, that same pin becomes an input and is checked together with side B. The outcome appears on an active-low error pin. The error pin is driven only in receive mode.

Each bidirectional pin is split into an input, an output value and an output enable, so the block maps directly onto chip pads. A parity select input chooses odd or even parity. Low selects even parity and high selects odd parity.

Top module: `octal_parity_xcvr`

## Requirements
- R1: With the block enabled (en_n low) and dir high, b_o equals a_i, every bit of b_oe is 1 and every bit of a_oe is 0.
- R2: With the block enabled and dir low, a_o equals b_i, every bit of a_oe is 1 and every bit of b_oe is 0.
- R3: With en_n high, a_oe, b_oe, par_oe and err_oe are all 0, whatever dir, odd_sel, the data and the parity input are.
- R4: In transmit with odd_sel low (even parity), par_o is 1 exactly when a_i holds an odd number of ones, so that A plus the parity bit has an even count.
- R5: In transmit with odd_sel high (odd parity), par_o is 1 exactly when a_i holds an even number of ones, so that A plus the parity bit has an odd count.
- R6: par_oe is 1 only when the block is enabled and dir is high. In every other case the parity pin acts as an input.
- R7: In receive, err_n_o is 1 (no error) when the number of ones in b_i plus par_i is even under odd_sel low, or odd under odd_sel high. Otherwise err_n_o is 0.
- R8: err_oe is 1 only when the block is enabled and dir is low. The error pin is undriven in transmit and when the block is disabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| en_n | input | 1 | Active-low enable for all driven pins |
| dir | input | 1 | 1: A to B (transmit), 0: B to A (receive) |
| odd_sel | input | 1 | Parity scheme: 0 even, 1 odd |
| a_i | input | DATA_W | Value sensed on side A pins |
| a_o | output | DATA_W | Value driven onto side A pins |
| a_oe | output | DATA_W | Per-pin drive enable for side A |
| b_i | input | DATA_W | Value sensed on side B pins |
| b_o | output | DATA_W | Value driven onto side B pins |
| b_oe | output | DATA_W | Per-pin drive enable for side B |
| par_i | input | 1 | Value sensed on the parity pin |
| par_o | output | 1 | Generated parity bit |
| par_oe | output | 1 | Drive enable for the parity pin |
| err_n_o | output | 1 | Check result, 0 on a parity mismatch |
| err_oe | output | 1 | Drive enable for the error pin |

## Verification
The checker asserts, whenever any input changes, that the enables are mutually exclusive and follow direction and enable. It also checks that the driven data copies the source side, and that the parity and error values agree with a population count computed independently of the reduction tree. The bench adds what only stimulus coverage can show. It sweeps every enable, direction and select combination over all 256 data words and both parity-input levels, so every count class and both schemes are exercised against arithmetic expectations.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;
  typedef enum logic {
    FLOW_B2A = 1'b0,
    FLOW_A2B = 1'b1
  } flow_e;

  typedef enum logic {
    SCHEME_EVEN = 1'b0,
    SCHEME_ODD  = 1'b1
  } scheme_e;

  typedef struct packed {
    logic a_drv;
    logic b_drv;
    logic par_drv;
    logic err_drv;
  } drive_t;
endpackage

// File: rtl/xor_tree.sv
module xor_tree #(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] vec_i,
  output logic             odd_o
);
  logic [WIDTH-1:0] acc;

  assign acc[0] = vec_i[0];

  generate
    for (genvar g = 1; g < WIDTH; g++) begin : g_stage
      assign acc[g] = acc[g-1] ^ vec_i[g];
    end
  endgenerate

  assign odd_o = acc[WIDTH-1];
endmodule

// File: rtl/drive_ctrl.sv
module drive_ctrl
  import xcvr_pkg::*;
(
  input  logic   en_n,
  input  flow_e  flow,
  output drive_t drv
);
  logic active;

  always_comb begin
    active      = ~en_n;
    drv.a_drv   = active && (flow == FLOW_B2A);
    drv.b_drv   = active && (flow == FLOW_A2B);
    drv.par_drv = active && (flow == FLOW_A2B);
    drv.err_drv = active && (flow == FLOW_B2A);
  end
endmodule

// File: rtl/parity_unit.sv
module parity_unit
  import xcvr_pkg::*;
(
  input  scheme_e scheme,
  input  logic    a_odd,
  input  logic    b_odd,
  input  logic    par_in,
  output logic    par_gen,
  output logic    chk_ok
);
  logic scheme_bit;

  always_comb begin
    scheme_bit = (scheme == SCHEME_ODD);
    par_gen    = a_odd ^ scheme_bit;
    chk_ok     = ~(b_odd ^ par_in ^ scheme_bit);
  end
endmodule

// File: rtl/octal_parity_xcvr.sv
module octal_parity_xcvr
  import xcvr_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              en_n,
  input  logic              dir,
  input  logic              odd_sel,
  input  logic [DATA_W-1:0] a_i,
  output logic [DATA_W-1:0] a_o,
  output logic [DATA_W-1:0] a_oe,
  input  logic [DATA_W-1:0] b_i,
  output logic [DATA_W-1:0] b_o,
  output logic [DATA_W-1:0] b_oe,
  input  logic              par_i,
  output logic              par_o,
  output logic              par_oe,
  output logic              err_n_o,
  output logic              err_oe
);
  flow_e   flow;
  scheme_e scheme;
  drive_t  drv;
  logic    a_odd;
  logic    b_odd;

  assign flow   = flow_e'(dir);
  assign scheme = scheme_e'(odd_sel);

  drive_ctrl u_drive (
    .en_n (en_n),
    .flow (flow),
    .drv  (drv)
  );

  xor_tree #(.WIDTH(DATA_W)) u_tree_a (
    .vec_i (a_i),
    .odd_o (a_odd)
  );

  xor_tree #(.WIDTH(DATA_W)) u_tree_b (
    .vec_i (b_i),
    .odd_o (b_odd)
  );

  parity_unit u_par (
    .scheme  (scheme),
    .a_odd   (a_odd),
    .b_odd   (b_odd),
    .par_in  (par_i),
    .par_gen (par_o),
    .chk_ok  (err_n_o)
  );

  assign a_o    = b_i;
  assign b_o    = a_i;
  assign a_oe   = {DATA_W{drv.a_drv}};
  assign b_oe   = {DATA_W{drv.b_drv}};
  assign par_oe = drv.par_drv;
  assign err_oe = drv.err_drv;
endmodule

// File: rtl/octal_parity_xcvr_chk.sv
module octal_parity_xcvr_chk #(
  parameter int DATA_W = 8
) (
  input logic              en_n,
  input logic              dir,
  input logic              odd_sel,
  input logic [DATA_W-1:0] a_i,
  input logic [DATA_W-1:0] a_o,
  input logic [DATA_W-1:0] a_oe,
  input logic [DATA_W-1:0] b_i,
  input logic [DATA_W-1:0] b_o,
  input logic [DATA_W-1:0] b_oe,
  input logic              par_i,
  input logic              par_o,
  input logic              par_oe,
  input logic              err_n_o,
  input logic              err_oe
);
  always_comb begin
    if (!en_n && dir) begin
      AST_A2B_DATA: assert (b_o == a_i && &b_oe && a_oe == '0); // R1
      AST_EVEN_GEN: assert (odd_sel || par_o == $countones(a_i) % 2); // R4
      AST_ODD_GEN: assert (!odd_sel || par_o != $countones(a_i) % 2); // R5
    end
    if (!en_n && !dir) begin
      AST_B2A_DATA: assert (a_o == b_i && &a_oe && b_oe == '0); // R2
      AST_CHECK_OK: assert (err_n_o == ((($countones(b_i) + par_i) % 2) == odd_sel)); // R7
    end
    if (en_n) begin
      AST_ALL_FLOAT: assert (a_oe == '0 && b_oe == '0 && !par_oe && !err_oe); // R3
    end
    AST_PAR_DRIVE: assert (!par_oe || (!en_n && dir)); // R6
    AST_ERR_DRIVE: assert (!err_oe || (!en_n && !dir)); // R8
    AST_PIN_EXCL: assert (!(par_oe && err_oe)); // R6
  end
endmodule

bind octal_parity_xcvr octal_parity_xcvr_chk #(.DATA_W(DATA_W)) u_chk (
  .en_n    (en_n),
  .dir     (dir),
  .odd_sel (odd_sel),
  .a_i     (a_i),
  .a_o     (a_o),
  .a_oe    (a_oe),
  .b_i     (b_i),
  .b_o     (b_o),
  .b_oe    (b_oe),
  .par_i   (par_i),
  .par_o   (par_o),
  .par_oe  (par_oe),
  .err_n_o (err_n_o),
  .err_oe  (err_oe)
);

// File: tb/test_octal_parity_xcvr.sv
module test_octal_parity_xcvr;
  localparam int W = 8;

  logic         clk;
  logic         en_n, dir, odd_sel, par_i;
  logic [W-1:0] a_i, b_i;
  logic [W-1:0] a_o, a_oe, b_o, b_oe;
  logic         par_o, par_oe, err_n_o, err_oe;
  int           checks, errors;
  logic         done;

  octal_parity_xcvr #(.DATA_W(W)) i_octal_parity_xcvr (
    .en_n(en_n), .dir(dir), .odd_sel(odd_sel),
    .a_i(a_i), .a_o(a_o), .a_oe(a_oe),
    .b_i(b_i), .b_o(b_o), .b_oe(b_oe),
    .par_i(par_i), .par_o(par_o), .par_oe(par_oe),
    .err_n_o(err_n_o), .err_oe(err_oe)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic int ones(input logic [W-1:0] v);
    int n = 0;
    for (int k = 0; k < W; k++) n += int'(v[k]);
    return n;
  endfunction

  initial begin
    done = 1'b0;
    #4000000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    checks = 0;
    errors = 0;
    en_n = 1'b1; dir = 1'b1; odd_sel = 1'b0; par_i = 1'b0;
    a_i = '0; b_i = '0;
    @(negedge clk);
    #2;
    // R3: idle state with the enable released
    chk("R3", {a_oe, b_oe} == '0 ? 8'd0 : 8'd1, 8'd0);
    chk("R3", {6'd0, par_oe, err_oe}, 8'd0);

    for (int e = 0; e < 2; e++) begin
      for (int d = 0; d < 2; d++) begin
        for (int s = 0; s < 2; s++) begin
          for (int v = 0; v < 256; v++) begin
            for (int p = 0; p < 2; p++) begin
              logic [W-1:0] dat;
              logic         act;
              logic         exp_par;
              logic         exp_ok;
              @(negedge clk);
              dat     = W'(v);
              en_n    = e[0];
              dir     = d[0];
              odd_sel = s[0];
              par_i   = p[0];
              a_i     = dat;
              b_i     = ~dat ^ W'(p * 8'h5A);
              #2;
              act     = !en_n;
              exp_par = ((ones(a_i) % 2) == 1) ^ odd_sel;
              exp_ok  = ((ones(b_i) + int'(par_i)) % 2) == int'(odd_sel);
              if (act && dir) begin
                chk("R1", b_o, a_i);
                chk("R1", b_oe, '1);
                chk("R1", a_oe, '0);
                if (!odd_sel) chk("R4", {7'd0, par_o}, {7'd0, exp_par});
                else          chk("R5", {7'd0, par_o}, {7'd0, exp_par});
              end
              if (act && !dir) begin
                chk("R2", a_o, b_i);
                chk("R2", a_oe, '1);
                chk("R2", b_oe, '0);
                chk("R7", {7'd0, err_n_o}, {7'd0, exp_ok});
              end
              if (!act) begin
                chk("R3", a_oe, '0);
                chk("R3", b_oe, '0);
              end
              chk("R6", {7'd0, par_oe}, {7'd0, act && dir});
              chk("R8", {7'd0, err_oe}, {7'd0, act && !dir});
            end
          end
        end
      end
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule